// File: doc/BRIEF.md
# Parallel Port Receive Channel

This block is the receive side of a high-speed parallel data port. It samples a parallel data bus driven by an external source such as a converter, a programmable-logic device or a peer port. Samples pass through a small buffer and leave as 16-bit words on a valid/ready stream. Software-level configuration arrives on static inputs: the sample width, the output format, single or double data rate, and the use and active level of each strobe.

Each accepted sample is cut down to the configured width. It is then placed in the output word as a zero-extended value, a sign-extended value, or a left-aligned value with zeros below. An optional data-enable strobe qualifies individual clock edges. An optional frame-start strobe marks the next accepted sample with a start-of-frame flag. An optional wait output tells the sender to pause when the buffer is close to full. In double data rate mode, the bus is sampled on both clock edges. The two samples of one cycle then leave as two consecutive words, with the rising-edge sample first.

Top module: `prx_channel`

## Requirements
- R1: A synchronous active-high reset empties the buffer and drops `m_valid`. It also drives `pin_wait` to its inactive level, which is the inverse of `cfg_wait_pol`.
- R2: `cfg_width` selects a sample width of 8 to 16 bits. A value below 8 acts as 8 and a value above 16 acts as 16. Data bits at or above the effective width never affect the output word.
- R3: `cfg_just` = 0 (and the spare code 3) gives right-justified zero extension: the sample sits in the low bits and every bit above it is 0.
- R4: `cfg_just` = 1 gives right-justified sign extension: every bit above the sample copies sample bit width-1.
- R5: `cfg_just` = 2 gives left justification: the sample occupies the top width bits and the low 16-width bits are 0.
- R6: With `cfg_enable_en` = 1, a rising edge carries data only when `pin_enable` equals `cfg_enable_pol`. With `cfg_enable_en` = 0, every rising edge carries data and `pin_enable` is ignored.
- R7: With `cfg_start_en` = 1, a rising edge where `pin_start` equals `cfg_start_pol` causes the first accepted sample on that edge or a later edge to carry `m_sof` = 1. All other words carry 0. With `cfg_start_en` = 0, `m_sof` is always 0.
- R8: With `cfg_ddr` = 1, each accepted cycle yields two words. The first is the bus value at the rising edge and the second is the value at the following falling edge. Only the first can carry `m_sof`.
- R9: Words leave in capture order. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_sof` hold.
- R10: With `cfg_wait_en` = 1, `pin_wait` equals `cfg_wait_pol` while 2 or fewer of the 8 buffer entries are free, and is inverted otherwise. With `cfg_wait_en` = 0, it always sits at the inverse of `cfg_wait_pol`.
- R11: The buffer holds 8 entries and the output register holds one more word. Samples that arrive while the buffer is full are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; data is sampled on both edges in double rate mode |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 5 | Sample width in bits, clamped to 8..16 |
| cfg_just | input | 2 | Output format: 0 zero-extend, 1 sign-extend, 2 left-justify, 3 as 0 |
| cfg_ddr | input | 1 | 1 samples on both clock edges |
| cfg_start_en | input | 1 | Use the frame-start strobe |
| cfg_start_pol | input | 1 | Active level of the frame-start strobe |
| cfg_enable_en | input | 1 | Use the data-enable strobe |
| cfg_enable_pol | input | 1 | Active level of the data-enable strobe |
| cfg_wait_en | input | 1 | Drive the wait output |
| cfg_wait_pol | input | 1 | Active level of the wait output |
| pin_data | input | 16 | Parallel sample bus |
| pin_start | input | 1 | Frame-start strobe |
| pin_enable | input | 1 | Data-enable strobe |
| pin_wait | output | 1 | Flow-control output to the sender |
| m_data | output | 16 | Justified output word |
| m_sof | output | 1 | Start-of-frame flag for this word |
| m_valid | output | 1 | Output word present |
| m_ready | input | 1 | Consumer accepts the word |

## Verification
The assertions check four things on every cycle. Each justified lane word keeps its format shape for the current width and mode. The buffer level never passes its depth. A stalled output word holds. `pin_wait` matches the buffer level under a steady configuration. Only the bench scenarios can show that the right samples arrive, in order, with the right values. Those scenarios also cover strobe qualification and start-of-frame placement, the pairing order of double rate samples, and which samples are lost on overflow. For these checks, a model of the sender predicts each word arithmetically from what was driven on the pins.

// File: rtl/prx_pkg.sv
package prx_pkg;

  typedef enum logic [1:0] {
    JUST_RZERO = 2'd0,
    JUST_RSIGN = 2'd1,
    JUST_LEFT  = 2'd2,
    JUST_SPARE = 2'd3
  } just_e;

endpackage

// File: rtl/prx_capture.sv
module prx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_start,
  input  logic              pin_enable,
  input  logic              start_en,
  input  logic              start_pol,
  input  logic              enable_en,
  input  logic              enable_pol,
  output logic [DATA_W-1:0] rise_data,
  output logic [DATA_W-1:0] fall_data,
  output logic              beat_valid,
  output logic              beat_sof
);

  logic [DATA_W-1:0] rise_q;
  logic [DATA_W-1:0] fall_q;
  logic              start_q;
  logic              enable_q;
  logic              live_q;
  logic              sof_pend_q;
  logic              start_hit;

  // rising-edge pin register, strobes sampled with the data
  always_ff @(posedge clk) begin
    rise_q   <= pin_data;
    start_q  <= pin_start;
    enable_q <= pin_enable;
  end

  // falling-edge pin register for the second half of a double rate cycle
  always_ff @(negedge clk) begin
    fall_q <= pin_data;
  end

  always_comb begin
    start_hit  = live_q && start_en && (start_q == start_pol);
    beat_valid = live_q && (!enable_en || (enable_q == enable_pol));
    beat_sof   = beat_valid && (start_hit || sof_pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q     <= 1'b0;
      sof_pend_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (beat_valid)
        sof_pend_q <= 1'b0;
      else if (start_hit)
        sof_pend_q <= 1'b1;
    end
  end

  assign rise_data = rise_q;
  assign fall_data = fall_q;

endmodule

// File: rtl/prx_justify.sv
module prx_justify
  import prx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WW     = 5
) (
  input  logic [WW-1:0]     width_i,
  input  just_e             mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] word
);

  localparam logic [DATA_W:0] ONE = 1;
  localparam logic [WW-1:0]   FULL = WW'(DATA_W);

  logic [DATA_W:0]   ones;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] top_vec;

  always_comb begin
    ones    = (ONE << width_i) - ONE;
    mask    = ones[DATA_W-1:0];
    kept    = raw & mask;
    top_vec = kept >> (width_i - WW'(1));
    unique case (mode)
      JUST_RSIGN: word = top_vec[0] ? (kept | ~mask) : kept;
      JUST_LEFT:  word = kept << (FULL - width_i);
      default:    word = kept;
    endcase
  end

endmodule

// File: rtl/prx_fifo.sv
module prx_fifo #(
  parameter int WIDTH     = 34,
  parameter int DEPTH     = 8,
  parameter int WAIT_FREE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic [$clog2(DEPTH):0] level,
  input  logic             wait_en,
  input  logic             wait_pol,
  output logic             wait_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [LW-1:0]    level_q;
  logic [LW-1:0]    level_next;
  logic [LW-1:0]    free_next;
  logic             full;
  logic             do_wr;
  logic             do_rd;
  logic             busy_next;

  always_comb begin
    full       = (level_q == LW'(DEPTH));
    empty      = (level_q == '0);
    do_wr      = wr_en && !full;
    do_rd      = rd_en && !empty;
    level_next = level_q + LW'(do_wr) - LW'(do_rd);
    free_next  = LW'(DEPTH) - level_next;
    busy_next  = wait_en && (free_next <= LW'(WAIT_FREE));
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr)
      mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      wait_o  <= !wait_pol;
    end else begin
      if (do_wr)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_rd)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      level_q <= level_next;
      wait_o  <= busy_next ? wait_pol : !wait_pol;
    end
  end

  assign level = level_q;

endmodule

// File: rtl/prx_unpack.sv
module prx_unpack #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fifo_empty,
  input  logic [2*DATA_W+1:0]   fifo_entry,
  output logic                  fifo_pop,
  output logic [DATA_W-1:0]     m_data,
  output logic                  m_sof,
  output logic                  m_valid,
  input  logic                  m_ready
);

  localparam int EW = 2 * DATA_W + 2;

  logic              advance;
  logic              hi_pend;
  logic [DATA_W-1:0] hi_data;
  logic              e_sof;
  logic              e_pair;
  logic [DATA_W-1:0] e_hi;
  logic [DATA_W-1:0] e_lo;

  always_comb begin
    e_sof    = fifo_entry[EW-1];
    e_pair   = fifo_entry[EW-2];
    e_hi     = fifo_entry[2*DATA_W-1:DATA_W];
    e_lo     = fifo_entry[DATA_W-1:0];
    advance  = !m_valid || m_ready;
    fifo_pop = advance && !hi_pend && !fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_sof   <= 1'b0;
      m_data  <= '0;
      hi_pend <= 1'b0;
      hi_data <= '0;
    end else if (advance) begin
      if (hi_pend) begin
        m_data  <= hi_data;
        m_sof   <= 1'b0;
        m_valid <= 1'b1;
        hi_pend <= 1'b0;
      end else if (!fifo_empty) begin
        m_data  <= e_lo;
        m_sof   <= e_sof;
        m_valid <= 1'b1;
        hi_pend <= e_pair;
        hi_data <= e_hi;
      end else begin
        m_valid <= 1'b0;
        m_sof   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prx_channel.sv
module prx_channel
  import prx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MIN_W     = 8,
  parameter int DEPTH     = 8,
  parameter int WAIT_FREE = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DATA_W+1)-1:0] cfg_width,
  input  logic [1:0]                 cfg_just,
  input  logic                       cfg_ddr,
  input  logic                       cfg_start_en,
  input  logic                       cfg_start_pol,
  input  logic                       cfg_enable_en,
  input  logic                       cfg_enable_pol,
  input  logic                       cfg_wait_en,
  input  logic                       cfg_wait_pol,
  input  logic [DATA_W-1:0]          pin_data,
  input  logic                       pin_start,
  input  logic                       pin_enable,
  output logic                       pin_wait,
  output logic [DATA_W-1:0]          m_data,
  output logic                       m_sof,
  output logic                       m_valid,
  input  logic                       m_ready
);

  localparam int WW      = $clog2(DATA_W + 1);
  localparam int LW      = $clog2(DEPTH) + 1;
  localparam int ENTRY_W = 2 * DATA_W + 2;
  localparam int LANES   = 2;

  logic [WW-1:0]      width_c;
  logic [DATA_W-1:0]  rise_data;
  logic [DATA_W-1:0]  fall_data;
  logic               beat_valid;
  logic               beat_sof;
  logic [DATA_W-1:0]  lane_raw  [LANES];
  logic [DATA_W-1:0]  lane_word [LANES];
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] rd_entry;
  logic               fifo_empty;
  logic               fifo_pop;
  logic [LW-1:0]      fifo_level;
  just_e              mode;

  always_comb begin
    if (cfg_width < WW'(MIN_W))
      width_c = WW'(MIN_W);
    else if (cfg_width > WW'(DATA_W))
      width_c = WW'(DATA_W);
    else
      width_c = cfg_width;
    mode = just_e'(cfg_just);
  end

  prx_capture #(.DATA_W(DATA_W)) i_capture (
    .clk        (clk),
    .rst        (rst),
    .pin_data   (pin_data),
    .pin_start  (pin_start),
    .pin_enable (pin_enable),
    .start_en   (cfg_start_en),
    .start_pol  (cfg_start_pol),
    .enable_en  (cfg_enable_en),
    .enable_pol (cfg_enable_pol),
    .rise_data  (rise_data),
    .fall_data  (fall_data),
    .beat_valid (beat_valid),
    .beat_sof   (beat_sof)
  );

  assign lane_raw[0] = rise_data;
  assign lane_raw[1] = fall_data;

  // one formatter per edge lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    prx_justify #(.DATA_W(DATA_W), .WW(WW)) i_justify (
      .width_i (width_c),
      .mode    (mode),
      .raw     (lane_raw[g]),
      .word    (lane_word[g])
    );
  end

  // entry: {sof, pair, falling word, rising word}
  assign wr_entry = {beat_sof, cfg_ddr, lane_word[1], lane_word[0]};

  prx_fifo #(
    .WIDTH     (ENTRY_W),
    .DEPTH     (DEPTH),
    .WAIT_FREE (WAIT_FREE)
  ) i_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (beat_valid),
    .wr_data  (wr_entry),
    .rd_en    (fifo_pop),
    .rd_data  (rd_entry),
    .empty    (fifo_empty),
    .level    (fifo_level),
    .wait_en  (cfg_wait_en),
    .wait_pol (cfg_wait_pol),
    .wait_o   (pin_wait)
  );

  prx_unpack #(.DATA_W(DATA_W)) i_unpack (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_entry (rd_entry),
    .fifo_pop   (fifo_pop),
    .m_data     (m_data),
    .m_sof      (m_sof),
    .m_valid    (m_valid),
    .m_ready    (m_ready)
  );

endmodule

// File: rtl/prx_channel_chk.sv
module prx_channel_chk #(
  parameter int DATA_W    = 16,
  parameter int MIN_W     = 8,
  parameter int DEPTH     = 8,
  parameter int WAIT_FREE = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [$clog2(DATA_W+1)-1:0] cfg_width,
  input logic [1:0]                  cfg_just,
  input logic                        cfg_wait_en,
  input logic                        cfg_wait_pol,
  input logic                        pin_wait,
  input logic [DATA_W-1:0]           m_data,
  input logic                        m_sof,
  input logic                        m_valid,
  input logic                        m_ready,
  input logic [$clog2(DEPTH):0]      level,
  input logic [DATA_W-1:0]           word_rise,
  input logic [DATA_W-1:0]           word_fall
);

  localparam int WW = $clog2(DATA_W + 1);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [WW-1:0] wc;
  logic          busy_now;

  always_comb begin
    if (cfg_width < WW'(MIN_W))      wc = WW'(MIN_W);
    else if (cfg_width > WW'(DATA_W)) wc = WW'(DATA_W);
    else                              wc = cfg_width;
    busy_now = cfg_wait_en && ((LW'(DEPTH) - level) <= LW'(WAIT_FREE));
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!m_valid && level == '0)); // R1

  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (cfg_just == 2'd0 || cfg_just == 2'd3) |->
      (((word_rise >> wc) == '0) && ((word_fall >> wc) == '0))); // R3

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (cfg_just == 2'd1) |->
      (((word_rise >> (wc - WW'(1))) == '0) || ((~word_rise >> (wc - WW'(1))) == '0))); // R4

  AST_LEFT_FILL: assert property (@(posedge clk) disable iff (rst)
    (cfg_just == 2'd2) |-> (((word_rise << wc) == '0) && ((word_fall << wc) == '0))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof))); // R9

  AST_WAIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($stable(cfg_wait_en) && $stable(cfg_wait_pol)) |->
      (pin_wait == (busy_now ? cfg_wait_pol : !cfg_wait_pol))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R11

endmodule

bind prx_channel prx_channel_chk #(
  .DATA_W    (DATA_W),
  .MIN_W     (MIN_W),
  .DEPTH     (DEPTH),
  .WAIT_FREE (WAIT_FREE)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_width    (cfg_width),
  .cfg_just     (cfg_just),
  .cfg_wait_en  (cfg_wait_en),
  .cfg_wait_pol (cfg_wait_pol),
  .pin_wait     (pin_wait),
  .m_data       (m_data),
  .m_sof        (m_sof),
  .m_valid      (m_valid),
  .m_ready      (m_ready),
  .level        (fifo_level),
  .word_rise    (lane_word[0]),
  .word_fall    (lane_word[1])
);

// File: tb/test_prx_channel.sv
`timescale 1ns/1ps
module test_prx_channel;

  logic        clk;
  logic        rst;
  logic [4:0]  cfg_width;
  logic [1:0]  cfg_just;
  logic        cfg_ddr, cfg_start_en, cfg_start_pol, cfg_enable_en, cfg_enable_pol;
  logic        cfg_wait_en, cfg_wait_pol;
  logic [15:0] pin_data;
  logic        pin_start, pin_enable, pin_wait;
  logic [15:0] m_data;
  logic        m_sof, m_valid, m_ready;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // sender model configuration, applied alongside each driven beat
  int n_width = 16, n_just = 0;
  bit n_ddr = 0, n_st_en = 0, n_st_pol = 1, n_en_en = 1, n_en_pol = 1;
  bit pend = 0;
  int cap = -1;
  int ready_mode = 0;
  logic [31:0] seed = 32'h1234_5678;
  string cur_tag = "R1";

  logic [16:0] exp_q[$];
  string       tag_q[$];

  prx_channel i_prx_channel (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_just(cfg_just), .cfg_ddr(cfg_ddr),
    .cfg_start_en(cfg_start_en), .cfg_start_pol(cfg_start_pol),
    .cfg_enable_en(cfg_enable_en), .cfg_enable_pol(cfg_enable_pol),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
    .pin_data(pin_data), .pin_start(pin_start), .pin_enable(pin_enable), .pin_wait(pin_wait),
    .m_data(m_data), .m_sof(m_sof), .m_valid(m_valid), .m_ready(m_ready)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] conv(input logic [15:0] raw, input int wcfg, input int j);
    int w;
    logic [15:0] m, k;
    w = (wcfg < 8) ? 8 : ((wcfg > 16) ? 16 : wcfg);
    m = (w == 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
    k = raw & m;
    if (j == 1 && ((raw >> (w - 1)) & 16'd1) == 16'd1) k = k | ~m;
    if (j == 2) k = 16'(k << (16 - w));
    return k;
  endfunction

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input bit s);
    exp_q.push_back({s, d});
    tag_q.push_back(cur_tag);
  endtask

  task automatic drive_beat(input logic [15:0] r, input logic [15:0] f, input bit en, input bit st);
    bit valid, hit, s;
    @(negedge clk); #1;
    pin_data = r; pin_enable = en; pin_start = st;
    @(posedge clk); #1;
    pin_data = f;
    cfg_width = 5'(n_width); cfg_just = 2'(n_just); cfg_ddr = n_ddr;
    cfg_start_en = n_st_en; cfg_start_pol = n_st_pol;
    cfg_enable_en = n_en_en; cfg_enable_pol = n_en_pol;
    valid = !n_en_en || (en == n_en_pol);
    hit = n_st_en && (st == n_st_pol);
    if (valid) begin
      s = hit || pend;
      pend = 0;
      if (cap < 0) begin
        push(conv(r, n_width, n_just), s);
        if (n_ddr) push(conv(f, n_width, n_just), 1'b0);
      end else if (cap > 0) begin
        push(conv(r, n_width, n_just), s);
        cap--;
      end
    end else if (hit) begin
      pend = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_beat(rnd(), rnd(), !n_en_pol, !n_st_pol);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // output ready pattern: 0 low, 1 high, 2 two of three cycles
  initial begin
    int cyc = 0;
    m_ready = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (ready_mode)
        0: m_ready = 0;
        1: m_ready = 1;
        default: m_ready = (cyc % 3) != 0;
      endcase
    end
  end

  // scoreboard: transfer happens at the next rising edge
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, {cur_tag, " unexpected word"}, {15'd0, m_sof, m_data}, 32'hFFFF_FFFF);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({m_sof, m_data} == e, t, {15'd0, m_sof, m_data}, {15'd0, e});
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    cfg_width = 16; cfg_just = 0; cfg_ddr = 0;
    cfg_start_en = 0; cfg_start_pol = 1; cfg_enable_en = 1; cfg_enable_pol = 1;
    cfg_wait_en = 1; cfg_wait_pol = 1;
    pin_data = 0; pin_start = 0; pin_enable = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (2) @(negedge clk);
    chk(m_valid == 0, "R1 valid after reset", {31'd0, m_valid}, 0);
    chk(pin_wait == 0, "R1 wait after reset", {31'd0, pin_wait}, 0);
    ready_mode = 1;

    // width and format sweep: R2 with R3, R4, R5
    for (int w = 4; w <= 20; w++) begin
      for (int j = 0; j < 4; j++) begin
        n_width = w; n_just = j;
        case (j)
          1: cur_tag = "R2 R4";
          2: cur_tag = "R2 R5";
          default: cur_tag = "R2 R3";
        endcase
        for (int k = 0; k < 8; k++) begin
          int wc;
          logic [15:0] d;
          wc = (w < 8) ? 8 : ((w > 16) ? 16 : w);
          case (k)
            0: d = 16'hFFFF;
            1: d = 16'(32'd1 << (wc - 1));
            2: d = 16'(32'd1 << (wc - 1)) ^ 16'hFFFF;
            default: d = rnd();
          endcase
          drive_beat(d, rnd(), 1, 0);
        end
      end
    end
    idle(2); drain();

    // enable strobe, active low, start toggling while disabled: R6 and R7
    cur_tag = "R6"; n_width = 12; n_just = 1; n_en_pol = 0;
    for (int i = 0; i < 40; i++) drive_beat(rnd(), rnd(), rnd() % 2 == 1, rnd() % 2 == 1);
    n_en_en = 0;
    for (int i = 0; i < 20; i++) drive_beat(rnd(), rnd(), rnd() % 2 == 1, 0);
    n_en_en = 1; n_en_pol = 1;
    idle(2); drain();

    // frame start handling: R7
    cur_tag = "R7"; n_width = 10; n_just = 0; n_st_en = 1; n_st_pol = 1;
    drive_beat(16'h0111, 0, 0, 1);
    drive_beat(16'h0222, 0, 0, 0);
    drive_beat(16'h0333, 0, 1, 0);
    drive_beat(16'h0044, 0, 1, 1);
    drive_beat(16'h0055, 0, 1, 0);
    n_st_pol = 0;
    drive_beat(16'h0066, 0, 1, 1);
    drive_beat(16'h0077, 0, 1, 0);
    for (int i = 0; i < 30; i++) drive_beat(rnd(), 0, rnd() % 2 == 1, rnd() % 4 == 0);
    n_st_pol = 1;
    idle(2); drain();

    // double rate pairs: R8
    cur_tag = "R8"; n_ddr = 1; n_width = 12; n_just = 1;
    for (int i = 0; i < 30; i++) begin
      drive_beat(rnd(), rnd(), 1, (i % 7) == 0);
      idle(1);
    end
    n_just = 2;
    for (int i = 0; i < 10; i++) begin
      drive_beat(rnd(), rnd(), 1, (i % 3) == 0);
      idle(1);
    end
    n_ddr = 0; n_st_en = 0;
    idle(2); drain();

    // back-pressure and ordering: R9
    cur_tag = "R9"; ready_mode = 2; n_width = 16; n_just = 0;
    for (int i = 0; i < 60; i++) drive_beat(rnd(), 0, (i % 2) == 0, 0);
    idle(2);
    ready_mode = 1; drain();

    // wait threshold: R10
    cur_tag = "R10"; ready_mode = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 6; i++) drive_beat(rnd(), 0, 1, 0);
    idle(3);
    chk(pin_wait == 0, "R10 three entries free", {31'd0, pin_wait}, 0);
    drive_beat(rnd(), 0, 1, 0);
    idle(3);
    chk(pin_wait == 1, "R10 two entries free", {31'd0, pin_wait}, 1);
    cfg_wait_pol = 0;
    idle(2);
    chk(pin_wait == 0, "R10 active low", {31'd0, pin_wait}, 0);
    cfg_wait_en = 0;
    idle(2);
    chk(pin_wait == 1, "R10 disabled inactive", {31'd0, pin_wait}, 1);
    cfg_wait_en = 1; cfg_wait_pol = 1;
    ready_mode = 1; drain();
    chk(pin_wait == 0, "R10 released after drain", {31'd0, pin_wait}, 0);

    // overflow: 8 buffered plus 1 in the output register: R11
    cur_tag = "R11"; ready_mode = 0; cap = 9;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 12; i++) drive_beat(rnd(), 0, 1, 0);
    idle(2);
    cap = -1;
    ready_mode = 1; drain();
    idle(3);

    chk(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule